// File: doc/BRIEF.md
# USB Low-Speed Packet Receiver

This block recovers packets from the two single-ended lines of a low-speed USB link. It runs from a sample clock at eight times the bit rate. It registers the line pair and waits for an idle-to-K transition, which gives it the bit phase. It then checks the rest of the sync field until it finds the two consecutive K bits that close it. After lock, it samples every bit near its centre and turns line changes into data bits. It drops the bits inserted by the transmitter's stuffing rule and assembles bytes least significant bit first.

Each finished byte leaves on a one-cycle strobe with its data. The downstream buffer holds a bounded number of bytes, and the receiver counts against that bound. When both lines go low, the packet ends, and the receiver reports the number of whole bytes. A packet that breaks the stuffing rule, or that holds more bytes than the buffer, is dropped with an error pulse. The receiver then stays quiet until the line signals end of packet. Packet IDs, CRC and handshake replies are left to the logic that consumes the bytes.

Top module: `ls_packet_rx`

## Requirements
- R1: While reset is asserted and right after it is released, byteValid, pktEnd, overflowErr and stuffErr are all 0.
- R2: Line states are J = (dPlus 0, dMinus 1), K = (dPlus 1, dMinus 0) and SE0 = (both 0). Data is accepted only after an idle-to-K edge followed by K/J bit samples that end in two consecutive K samples. A sync field that never shows two Ks in a row produces no byte and no packet end.
- R3: A data bit is 1 when the sampled line level matches the previous bit's level and 0 when it differs. The reference level at the first data bit is the final K of the sync field.
- R4: After six consecutive data ones, the next bit is discarded. The sync field's closing one counts toward those six. A byte made entirely of ones is still delivered intact.
- R5: If the discarded bit shows no level change, stuffErr pulses for one cycle. The packet is then dropped without pktEnd, and the receiver waits for SE0 before it hunts again.
- R6: Bytes are assembled with the first received data bit in bit 0. Each byte appears on byteData together with a one-cycle byteValid pulse.
- R7: An SE0 sampled in bit slot 1 to 7 of a byte ends the packet. pktEnd then pulses once, and pktBytes equals the number of bytes delivered. A partial byte is discarded.
- R8: An SE0 sampled in bit slot 0 of a byte does not end the packet. It is taken as a K level, so a one-bit SE0 glitch there leaves the data unchanged, and a dribble bit before end of packet adds no byte.
- R9: The first BUF_BYTES bytes (default 8) of a packet are delivered. Completing byte BUF_BYTES+1 pulses overflowErr instead of byteValid, and no pktEnd follows for that packet.
- R10: byteValid, pktEnd, overflowErr and stuffErr are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, eight cycles per bit |
| rst_n | input | 1 | Asynchronous reset, active low |
| dPlus | input | 1 | Positive data line |
| dMinus | input | 1 | Negative data line |
| byteValid | output | 1 | One-cycle strobe for a received byte |
| byteData | output | 8 | Received byte, valid with byteValid |
| pktEnd | output | 1 | One-cycle strobe at end of packet |
| pktBytes | output | $clog2(BUF_BYTES+1) | Whole bytes in the packet, valid with pktEnd |
| overflowErr | output | 1 | Packet longer than the buffer, packet dropped |
| stuffErr | output | 1 | Missing transition after six ones, packet dropped |

## Verification
The bench sends packets of all-ones bytes, because a receiver that counts the run of ones wrongly either corrupts those bytes or raises a false stuffing error. It puts a one-bit SE0 into the first slot of a byte, and adds dribble and trailing partial bits before end of packet. A receiver that does not exempt the first slot cuts the packet short, and one that counts a partial byte reports the wrong length. It sends a sync field without the closing double K, which a receiver that locks too early turns into a phantom packet. It also sends packets of exactly the buffer size and one byte more, to show an off-by-one in the overflow bound.

// File: rtl/ls_rx_pkg.sv
package ls_rx_pkg;

  // Line states as {dPlus, dMinus}
  localparam logic [1:0] LINE_J   = 2'b01;
  localparam logic [1:0] LINE_K   = 2'b10;
  localparam logic [1:0] LINE_SE0 = 2'b00;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for the first idle-to-K edge
    ST_EDGE,   // inside sync, waiting for the next J-to-K edge
    ST_SAMP1,  // first K sample after an edge
    ST_SAMP2,  // second sample: K here closes the sync field
    ST_DATA,   // receiving packet bits
    ST_DRAIN   // packet dropped, waiting for SE0
  } rxState_e;

  // Control to datapath
  typedef struct packed {
    logic clearPhase;
    logic startData;
    logic dataSample;
  } rxStrobe_t;

  // Datapath to control
  typedef struct packed {
    logic edgeJK;
    logic sampleTick;
    logic lineK;
    logic lineSe0;
    logic endHit;
    logic abortHit;
  } rxStatus_t;

endpackage

// File: rtl/ls_rx_datapath.sv
module ls_rx_datapath
  import ls_rx_pkg::*;
#(
  parameter int BUF_BYTES  = 8,
  parameter int OVERSAMPLE = 8,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dPlus,
  input  logic             dMinus,
  input  rxStrobe_t        strobe,
  output rxStatus_t        status,
  output logic             byteValid,
  output logic [7:0]       byteData,
  output logic             pktEnd,
  output logic [CNT_W-1:0] pktBytes,
  output logic             overflowErr,
  output logic             stuffErr
);

  localparam int PHASE_W   = $clog2(OVERSAMPLE);
  localparam int CENTER    = OVERSAMPLE / 2 - 1;
  localparam int STUFF_RUN = 6;
  localparam int RUN_W     = $clog2(STUFF_RUN + 1);

  logic [1:0]         lineNow, linePrev;
  logic [PHASE_W-1:0] phase;
  logic               lastK;
  logic [RUN_W-1:0]   onesRun;
  logic [2:0]         bitIdx;
  logic [7:0]         shiftReg;
  logic [CNT_W-1:0]   byteCount;

  logic curK, se0, decoded, stuffSlot, tick;
  logic endRaw, takeRaw, stuffBad, byteDone, overHit;

  // Input capture and bit-phase counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lineNow  <= LINE_J;
      linePrev <= LINE_J;
      phase    <= '0;
    end else begin
      lineNow  <= {dPlus, dMinus};
      linePrev <= lineNow;
      if (strobe.clearPhase || phase == PHASE_W'(OVERSAMPLE - 1)) phase <= '0;
      else phase <= phase + PHASE_W'(1);
    end
  end

  assign tick      = (phase == PHASE_W'(CENTER));
  assign curK      = !lineNow[0];          // SE0 reads as K level
  assign se0       = (lineNow == LINE_SE0);
  assign decoded   = (curK == lastK);
  assign stuffSlot = (onesRun == RUN_W'(STUFF_RUN));
  assign endRaw    = tick && se0 && (bitIdx != 3'd0);
  assign takeRaw   = tick && !endRaw && !stuffSlot;
  assign stuffBad  = tick && !se0 && stuffSlot && decoded;
  assign byteDone  = takeRaw && (bitIdx == 3'd7);
  assign overHit   = byteDone && (byteCount == CNT_W'(BUF_BYTES));

  assign status.edgeJK     = (linePrev == LINE_J) && (lineNow == LINE_K);
  assign status.sampleTick = tick;
  assign status.lineK      = (lineNow == LINE_K);
  assign status.lineSe0    = se0;
  assign status.endHit     = endRaw;
  assign status.abortHit   = stuffBad || overHit;

  // Bit decoding, unstuffing and byte assembly
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastK     <= 1'b1;
      onesRun   <= '0;
      bitIdx    <= '0;
      shiftReg  <= '0;
      byteCount <= '0;
    end else if (strobe.startData) begin
      lastK     <= 1'b1;
      onesRun   <= RUN_W'(1);
      bitIdx    <= '0;
      byteCount <= '0;
    end else if (strobe.dataSample && !endRaw) begin
      lastK <= curK;
      if (stuffSlot) begin
        onesRun <= '0;
      end else begin
        onesRun  <= decoded ? onesRun + RUN_W'(1) : '0;
        shiftReg <= {decoded, shiftReg[7:1]};
        bitIdx   <= bitIdx + 3'd1;
        if (byteDone && !overHit) byteCount <= byteCount + CNT_W'(1);
      end
    end
  end

  // Registered result pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byteValid   <= 1'b0;
      byteData    <= '0;
      pktEnd      <= 1'b0;
      pktBytes    <= '0;
      overflowErr <= 1'b0;
      stuffErr    <= 1'b0;
    end else begin
      byteValid   <= strobe.dataSample && byteDone && !overHit;
      overflowErr <= strobe.dataSample && overHit;
      stuffErr    <= strobe.dataSample && stuffBad;
      pktEnd      <= strobe.dataSample && endRaw;
      if (strobe.dataSample && byteDone) byteData <= {decoded, shiftReg[7:1]};
      if (strobe.dataSample && endRaw) pktBytes <= byteCount;
    end
  end

endmodule

// File: rtl/ls_rx_ctrl.sv
module ls_rx_ctrl
  import ls_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  rxStatus_t status,
  output rxStrobe_t strobe
);

  rxState_e state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (status.edgeJK) begin
          nextState         = ST_SAMP1;
          strobe.clearPhase = 1'b1;
        end
      end
      ST_EDGE: begin
        if (status.lineSe0) nextState = ST_IDLE;
        else if (status.edgeJK) begin
          nextState         = ST_SAMP1;
          strobe.clearPhase = 1'b1;
        end
      end
      ST_SAMP1: begin
        if (status.lineSe0) nextState = ST_IDLE;
        else if (status.sampleTick) nextState = status.lineK ? ST_SAMP2 : ST_EDGE;
      end
      ST_SAMP2: begin
        if (status.lineSe0) nextState = ST_IDLE;
        else if (status.sampleTick) begin
          if (status.lineK) begin
            nextState        = ST_DATA;
            strobe.startData = 1'b1;
          end else begin
            nextState = ST_EDGE;
          end
        end
      end
      ST_DATA: begin
        strobe.dataSample = status.sampleTick;
        if (status.endHit) nextState = ST_IDLE;
        else if (status.abortHit) nextState = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (status.lineSe0) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/ls_packet_rx.sv
module ls_packet_rx
  import ls_rx_pkg::*;
#(
  parameter int  BUF_BYTES  = 8,
  parameter int  OVERSAMPLE = 8,
  localparam int CNT_W      = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dPlus,
  input  logic             dMinus,
  output logic             byteValid,
  output logic [7:0]       byteData,
  output logic             pktEnd,
  output logic [CNT_W-1:0] pktBytes,
  output logic             overflowErr,
  output logic             stuffErr
);

  rxStrobe_t strobe;
  rxStatus_t status;

  ls_rx_ctrl uCtrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (status),
    .strobe (strobe)
  );

  ls_rx_datapath #(
    .BUF_BYTES  (BUF_BYTES),
    .OVERSAMPLE (OVERSAMPLE),
    .CNT_W      (CNT_W)
  ) uPath (
    .clk         (clk),
    .rst_n       (rst_n),
    .dPlus       (dPlus),
    .dMinus      (dMinus),
    .strobe      (strobe),
    .status      (status),
    .byteValid   (byteValid),
    .byteData    (byteData),
    .pktEnd      (pktEnd),
    .pktBytes    (pktBytes),
    .overflowErr (overflowErr),
    .stuffErr    (stuffErr)
  );

endmodule

// File: rtl/ls_rx_checker.sv
module ls_rx_checker #(
  parameter int BUF_BYTES = 8,
  parameter int CNT_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byteValid,
  input logic             pktEnd,
  input logic [CNT_W-1:0] pktBytes,
  input logic             overflowErr,
  input logic             stuffErr
);

  logic [CNT_W-1:0] seenBytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seenBytes <= '0;
    else if (pktEnd || overflowErr || stuffErr) seenBytes <= '0;
    else if (byteValid) seenBytes <= seenBytes + CNT_W'(1);
  end

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byteValid, pktEnd, overflowErr, stuffErr}));

  assert_byte_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byteValid |=> !byteValid);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byteValid |-> (seenBytes < CNT_W'(BUF_BYTES)));

  assert_end_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pktEnd |-> (pktBytes == seenBytes));

endmodule

bind ls_packet_rx ls_rx_checker #(
  .BUF_BYTES (BUF_BYTES),
  .CNT_W     (CNT_W)
) uChk (
  .clk         (clk),
  .rst_n       (rst_n),
  .byteValid   (byteValid),
  .pktEnd      (pktEnd),
  .pktBytes    (pktBytes),
  .overflowErr (overflowErr),
  .stuffErr    (stuffErr)
);

// File: tb/sim_ls_packet_rx.sv
module sim_ls_packet_rx;

  localparam int BUF = 8;
  localparam int CW  = $clog2(BUF + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dPlus = 1'b0;
  logic dMinus = 1'b1;
  logic byteValid, pktEnd, overflowErr, stuffErr;
  logic [7:0] byteData;
  logic [CW-1:0] pktBytes;

  always #2 clk = ~clk;

  ls_packet_rx #(.BUF_BYTES(BUF)) u0 (
    .clk(clk), .rst_n(rst_n), .dPlus(dPlus), .dMinus(dMinus),
    .byteValid(byteValid), .byteData(byteData), .pktEnd(pktEnd),
    .pktBytes(pktBytes), .overflowErr(overflowErr), .stuffErr(stuffErr)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] got[$];
  int endSeen, ovfSeen, stuffSeen, multiSeen, lastEndBytes;
  logic [7:0] pkt [0:15];
  bit curK;
  int ones;
  bit glitchArmed;

  always @(negedge clk) begin
    if (byteValid) got.push_back(byteData);
    if (pktEnd) begin endSeen++; lastEndBytes = int'(pktBytes); end
    if (overflowErr) ovfSeen++;
    if (stuffErr) stuffSeen++;
    if ((int'(byteValid) + int'(pktEnd) + int'(overflowErr) + int'(stuffErr)) > 1) multiSeen++;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearCapture();
    got.delete();
    endSeen = 0; ovfSeen = 0; stuffSeen = 0; lastEndBytes = -1;
  endtask

  task automatic putLevel(bit k, bit se0);
    dPlus  = se0 ? 1'b0 : k;
    dMinus = se0 ? 1'b0 : !k;
    repeat (8) @(negedge clk);
  endtask

  task automatic sendBit(bit b, bit allowStuff, bit slot0);
    if (!b) curK = !curK;
    if (slot0 && glitchArmed && curK) begin
      putLevel(1'b1, 1'b1);
      glitchArmed = 1'b0;
    end else begin
      putLevel(curK, 1'b0);
    end
    if (b) ones++; else ones = 0;
    if (ones == 6) begin
      ones = 0;
      if (allowStuff) begin
        curK = !curK;
        putLevel(curK, 1'b0);
      end
    end
  endtask

  task automatic sendPacket(int n, int extra, bit breakStuff, bit glitch);
    clearCapture();
    curK = 1'b0; ones = 0; glitchArmed = glitch;
    repeat (3) putLevel(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) sendBit(i == 7, 1'b1, 1'b0);
    for (int b = 0; b < n; b++)
      for (int i = 0; i < 8; i++) sendBit(pkt[b][i], !breakStuff, (i == 0) && (b >= 1));
    for (int e = 0; e < extra; e++) sendBit(1'($urandom_range(1, 0)), 1'b1, 1'b0);
    repeat (2) putLevel(1'b0, 1'b1);
    repeat (4) putLevel(1'b0, 1'b0);
  endtask

  task automatic verifyPacket(string req, int expBytes, int expEnd, int expOvf, int expStuff);
    check(got.size() == expBytes, req, "byte count", got.size(), expBytes);
    for (int i = 0; i < expBytes && i < got.size(); i++)
      check(got[i] == pkt[i], req, $sformatf("byte %0d", i), int'(got[i]), int'(pkt[i]));
    check(endSeen == expEnd, req, "pktEnd pulses", endSeen, expEnd);
    if (expEnd == 1) check(lastEndBytes == expBytes, req, "pktBytes", lastEndBytes, expBytes);
    check(ovfSeen == expOvf, req, "overflowErr pulses", ovfSeen, expOvf);
    check(stuffSeen == expStuff, req, "stuffErr pulses", stuffSeen, expStuff);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (5) @(negedge clk);
    // R1: reset state
    check(!byteValid && !pktEnd && !overflowErr && !stuffErr, "R1", "outputs in reset",
          int'({byteValid, pktEnd, overflowErr, stuffErr}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!byteValid && !pktEnd && !overflowErr && !stuffErr, "R1", "outputs after reset",
          int'({byteValid, pktEnd, overflowErr, stuffErr}), 0);

    // R3 R6 R7: mixed bytes
    pkt[0] = 8'hC3; pkt[1] = 8'h2D; pkt[2] = 8'h10;
    sendPacket(3, 0, 1'b0, 1'b0);
    verifyPacket("R3 R6 R7 mixed", 3, 1, 0, 0);

    // R4: all ones, heavy stuffing
    for (int i = 0; i < 4; i++) pkt[i] = 8'hFF;
    sendPacket(4, 0, 1'b0, 1'b0);
    verifyPacket("R4 all ones", 4, 1, 0, 0);

    // R3: all zeros, toggle every bit
    for (int i = 0; i < 3; i++) pkt[i] = 8'h00;
    sendPacket(3, 0, 1'b0, 1'b0);
    verifyPacket("R3 all zeros", 3, 1, 0, 0);

    // R8: dribble bit before end of packet
    pkt[0] = 8'hA5; pkt[1] = 8'h7E;
    sendPacket(2, 1, 1'b0, 1'b0);
    verifyPacket("R8 dribble", 2, 1, 0, 0);

    // R8: one-bit SE0 in slot 0 of byte 1 (level K there)
    pkt[0] = 8'h01; pkt[1] = 8'h00; pkt[2] = 8'h5A;
    sendPacket(3, 0, 1'b0, 1'b1);
    check(glitchArmed == 1'b0, "R8", "glitch injected", int'(glitchArmed), 0);
    verifyPacket("R8 slot0 SE0", 3, 1, 0, 0);

    // R7: partial byte discarded
    pkt[0] = 8'h96; pkt[1] = 8'h3C;
    sendPacket(2, 5, 1'b0, 1'b0);
    verifyPacket("R7 partial", 2, 1, 0, 0);

    // R9: exactly buffer size
    for (int i = 0; i < BUF; i++) pkt[i] = 8'(i * 37 + 11);
    sendPacket(BUF, 0, 1'b0, 1'b0);
    verifyPacket("R9 full buffer", BUF, 1, 0, 0);

    // R9: one byte too many
    for (int i = 0; i <= BUF; i++) pkt[i] = 8'(i * 53 + 7);
    sendPacket(BUF + 1, 0, 1'b0, 1'b0);
    verifyPacket("R9 overflow", BUF, 0, 1, 0);

    // R5: missing stuffed transition
    pkt[0] = 8'hFF; pkt[1] = 8'hFF;
    sendPacket(2, 0, 1'b1, 1'b0);
    verifyPacket("R5 stuff error", 0, 0, 0, 1);

    // R2: sync without double K
    clearCapture();
    repeat (3) putLevel(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin putLevel(1'b1, 1'b0); putLevel(1'b0, 1'b0); end
    repeat (3) putLevel(1'b0, 1'b0);
    repeat (2) putLevel(1'b0, 1'b1);
    repeat (4) putLevel(1'b0, 1'b0);
    verifyPacket("R2 bad sync", 0, 0, 0, 0);

    // R2: lock again after the bad sync
    pkt[0] = 8'h4B;
    sendPacket(1, 0, 1'b0, 1'b0);
    verifyPacket("R2 relock", 1, 1, 0, 0);

    // R6 R7: random packets
    for (int p = 0; p < 15; p++) begin
      int n;
      n = $urandom_range(BUF, 1);
      for (int i = 0; i < n; i++) pkt[i] = 8'($urandom);
      sendPacket(n, $urandom_range(7, 0), 1'b0, 1'b0);
      verifyPacket("R6 R7 random", n, 1, 0, 0);
    end

    // R10: never two pulses in one cycle
    check(multiSeen == 0, "R10", "cycles with overlapping pulses", multiSeen, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule